// File: doc/BRIEF.md
# Page-Boundary Over-Read Predictor

This block takes one DMA transfer descriptor (a start address, an element size, an element count, a source stride) together with a mode code. The mode code says which over-read pattern the transfer is known to trigger. From these the block works out the spurious reads that a faulty transfer engine issues when its source elements run across 4 KB page boundaries. It presents those reads as a stream of records, each holding a start address and a byte length, on a valid/ready output that marks the final record. A bus monitor can line these records up against the reads it observes. Deciding the mode code is done elsewhere, and the block issues no bus traffic itself.

The per-element and single-crossing modes walk the element addresses one per clock cycle. For each element the block takes the offset inside the page and tests whether the element spills past the page end. The merged mode and the "nothing expected" mode need no walk. Each descriptor ends with exactly one record that carries the last flag. When a descriptor predicts nothing, that final record is a zero-address, zero-length marker, so a consumer always sees where a descriptor ends.

Top module: `extra_read_predictor`

## Requirements
- R1: After reset, descReady is 1 and recValid is 0.
- R2: A descriptor is taken on a clock edge with descValid and descReady both high. descReady then stays 0 until the record carrying recLast has been handed over, and returns to 1 on the cycle that follows that handover.
- R3: Mode 0 (per-element): for each i from 0 to BCNT-1, let a(i) = SRC + i*STRIDE and let x(i) be the low 12 bits of a(i). Element i crosses when x(i) + ACNT > 4096. Each crossing element gives one record with address a(i) + STRIDE and length 4096 - x(i).
- R4: Records leave in ascending element order, one per valid/ready handshake. recLast is 1 on the final record of a descriptor and 0 on every other record.
- R5: In mode 0, every non-zero record length is strictly less than ACNT.
- R6: Mode 1 (single-crossing): only the lowest crossing index i counts. It gives one record with address SRC + BCNT*ACNT and length 4096 - x(i). Any later crossing is ignored.
- R7: Mode 2 (merged): exactly one record is produced, with address SRC + BCNT*ACNT, length ACNT and recLast set. No walk takes place.
- R8: A descriptor that yields no records gives a single record with address 0, length 0 and recLast 1. This happens in mode 3, with BCNT = 0, or in mode 0 or 1 when no element crosses. A zero-length record always carries recLast.
- R9: While recValid is 1 and recReady is 0, recValid, recAddr, recLen and recLast hold their values into the next cycle.
- R10: Address sums are 32 bits wide and wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| descValid | input | 1 | Descriptor offered |
| descReady | output | 1 | Block idle, descriptor can be taken |
| descMode | input | 2 | 0 per-element, 1 single-crossing, 2 merged, 3 none |
| descSrc | input | 32 | Source start address |
| descAcnt | input | 16 | Element size in bytes |
| descBcnt | input | 16 | Element count |
| descStride | input | 16 | Unsigned source stride in bytes |
| recValid | output | 1 | Record available |
| recReady | input | 1 | Consumer takes the record |
| recAddr | output | 32 | Predicted over-read start address |
| recLen | output | 16 | Predicted over-read length in bytes |
| recLast | output | 1 | Final record of the descriptor |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16-bit lengths, counts and strides, and 12-bit page offsets. Page crossings therefore come from strides of a few kilobytes, and start addresses close to the top of the 32-bit space bring the wraparound of R10 within reach. Random element counts up to 24 with random consumer stalls push several pending records through the hold path of R9. The directed cases cover zero counts, mode 3, descriptors with no crossing, and single-crossing descriptors that contain more than one crossing.

// File: rtl/erp_pkg.sv
package erp_pkg;

  typedef enum logic [1:0] {
    MODE_PER_ELEM = 2'd0,
    MODE_SINGLE   = 2'd1,
    MODE_MERGED   = 2'd2,
    MODE_NONE     = 2'd3
  } erp_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // register a new descriptor
    logic advance;  // step to the next element
    logic capture;  // store the current crossing as the pending record
  } erp_ctrl_t;

endpackage

// File: rtl/erp_datapath.sv
module erp_datapath
  import erp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  erp_ctrl_t         ctrl,
  input  logic [1:0]        descMode,
  input  logic [ADDR_W-1:0] descSrc,
  input  logic [LEN_W-1:0]  descAcnt,
  input  logic [CNT_W-1:0]  descBcnt,
  input  logic [LEN_W-1:0]  descStride,
  output logic              crossNow,
  output logic              scanDone,
  output logic              havePend,
  output logic              isSingle,
  output logic [ADDR_W-1:0] recAddr,
  output logic [LEN_W-1:0]  recLen
);

  localparam int PAGE_SIZE = 1 << PAGE_BITS;

  logic [LEN_W-1:0]     acnt;
  logic [LEN_W-1:0]     stride;
  logic [CNT_W-1:0]     bcnt;
  logic [CNT_W-1:0]     idx;
  logic [1:0]           mode;
  logic [ADDR_W-1:0]    elemAddr;
  logic [ADDR_W-1:0]    endAddr;
  logic [ADDR_W-1:0]    pendAddr;
  logic [LEN_W-1:0]     pendLen;
  logic [ADDR_W-1:0]    descEnd;
  logic [PAGE_BITS-1:0] pageOff;
  logic [LEN_W:0]       reach;
  logic [LEN_W-1:0]     pageLen;

  assign descEnd  = descSrc + ADDR_W'(descBcnt) * ADDR_W'(descAcnt);
  assign pageOff  = elemAddr[PAGE_BITS-1:0];
  assign reach    = (LEN_W+1)'(pageOff) + (LEN_W+1)'(acnt);
  assign crossNow = reach > (LEN_W+1)'(PAGE_SIZE);
  assign pageLen  = LEN_W'(PAGE_SIZE) - LEN_W'(pageOff);
  assign scanDone = (idx == bcnt);
  assign isSingle = (mode == MODE_SINGLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acnt     <= '0;
      stride   <= '0;
      bcnt     <= '0;
      idx      <= '0;
      mode     <= MODE_NONE;
      elemAddr <= '0;
      endAddr  <= '0;
      pendAddr <= '0;
      pendLen  <= '0;
      havePend <= 1'b0;
    end else if (ctrl.load) begin
      acnt     <= descAcnt;
      stride   <= descStride;
      bcnt     <= descBcnt;
      idx      <= '0;
      mode     <= descMode;
      elemAddr <= descSrc;
      endAddr  <= descEnd;
      pendAddr <= descEnd;
      pendLen  <= descAcnt;
      havePend <= (descMode == MODE_MERGED);
    end else begin
      if (ctrl.capture) begin
        havePend <= 1'b1;
        pendAddr <= isSingle ? endAddr : elemAddr + ADDR_W'(stride);
        pendLen  <= pageLen;
      end
      if (ctrl.advance) begin
        idx      <= idx + 1'b1;
        elemAddr <= elemAddr + ADDR_W'(stride);
      end
    end
  end

  // a descriptor without any pending record ends on a zero marker
  assign recAddr = havePend ? pendAddr : '0;
  assign recLen  = havePend ? pendLen  : '0;

endmodule

// File: rtl/erp_control.sv
module erp_control
  import erp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       descValid,
  input  logic [1:0] descMode,
  input  logic       crossNow,
  input  logic       scanDone,
  input  logic       havePend,
  input  logic       isSingle,
  input  logic       recReady,
  output logic       descReady,
  output logic       recValid,
  output logic       recLast,
  output erp_ctrl_t  ctrl
);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FLUSH} state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext    = state;
    ctrl         = '0;
    descReady    = 1'b0;
    recValid     = 1'b0;
    recLast      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        descReady = 1'b1;
        if (descValid) begin
          ctrl.load = 1'b1;
          stateNext = (descMode == MODE_PER_ELEM || descMode == MODE_SINGLE)
                      ? ST_SCAN : ST_FLUSH;
        end
      end
      ST_SCAN: begin
        if (scanDone) begin
          stateNext = ST_FLUSH;
        end else if (crossNow && havePend && !isSingle) begin
          // previous record goes out before the new one replaces it
          recValid = 1'b1;
          if (recReady) begin
            ctrl.capture = 1'b1;
            ctrl.advance = 1'b1;
          end
        end else begin
          ctrl.capture = crossNow && !havePend;
          ctrl.advance = 1'b1;
        end
      end
      ST_FLUSH: begin
        recValid = 1'b1;
        recLast  = 1'b1;
        if (recReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/extra_read_predictor.sv
module extra_read_predictor
  import erp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descValid,
  output logic              descReady,
  input  logic [1:0]        descMode,
  input  logic [ADDR_W-1:0] descSrc,
  input  logic [LEN_W-1:0]  descAcnt,
  input  logic [CNT_W-1:0]  descBcnt,
  input  logic [LEN_W-1:0]  descStride,
  output logic              recValid,
  input  logic              recReady,
  output logic [ADDR_W-1:0] recAddr,
  output logic [LEN_W-1:0]  recLen,
  output logic              recLast
);

  erp_ctrl_t ctrl;
  logic      crossNow;
  logic      scanDone;
  logic      havePend;
  logic      isSingle;

  erp_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .descValid (descValid),
    .descMode  (descMode),
    .crossNow  (crossNow),
    .scanDone  (scanDone),
    .havePend  (havePend),
    .isSingle  (isSingle),
    .recReady  (recReady),
    .descReady (descReady),
    .recValid  (recValid),
    .recLast   (recLast),
    .ctrl      (ctrl)
  );

  erp_datapath #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .CNT_W     (CNT_W),
    .PAGE_BITS (PAGE_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .descMode   (descMode),
    .descSrc    (descSrc),
    .descAcnt   (descAcnt),
    .descBcnt   (descBcnt),
    .descStride (descStride),
    .crossNow   (crossNow),
    .scanDone   (scanDone),
    .havePend   (havePend),
    .isSingle   (isSingle),
    .recAddr    (recAddr),
    .recLen     (recLen)
  );

endmodule

// File: rtl/erp_checker.sv
module erp_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              descValid,
  input logic              descReady,
  input logic [1:0]        descMode,
  input logic [LEN_W-1:0]  descAcnt,
  input logic              recValid,
  input logic              recReady,
  input logic [ADDR_W-1:0] recAddr,
  input logic [LEN_W-1:0]  recLen,
  input logic              recLast
);

  logic [1:0]       savedMode;
  logic [LEN_W-1:0] savedAcnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedMode <= 2'd3;
      savedAcnt <= '0;
    end else if (descValid && descReady) begin
      savedMode <= descMode;
      savedAcnt <= descAcnt;
    end
  end

  p_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    descValid && descReady |=> !descReady);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(descReady && recValid));

  p_return_r4: assert property (@(posedge clk) disable iff (!rstN)
    recValid && recReady && recLast |=> descReady);

  p_shorter_r5: assert property (@(posedge clk) disable iff (!rstN)
    recValid && savedMode == 2'd0 && recLen != '0 |-> recLen < savedAcnt);

  p_merged_r7: assert property (@(posedge clk) disable iff (!rstN)
    recValid && savedMode == 2'd2 |-> recLast && recLen == savedAcnt);

  p_zero_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    recValid && recLen == '0 |-> recLast);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recReady |=> recValid && $stable(recAddr) && $stable(recLen)
                              && $stable(recLast));

endmodule

bind extra_read_predictor erp_checker #(
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .descValid (descValid),
  .descReady (descReady),
  .descMode  (descMode),
  .descAcnt  (descAcnt),
  .recValid  (recValid),
  .recReady  (recReady),
  .recAddr   (recAddr),
  .recLen    (recLen),
  .recLast   (recLast)
);

// File: tb/extra_read_predictor_test.sv
module extra_read_predictor_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        descValid = 1'b0;
  logic        descReady;
  logic [1:0]  descMode = '0;
  logic [31:0] descSrc = '0;
  logic [15:0] descAcnt = '0;
  logic [15:0] descBcnt = '0;
  logic [15:0] descStride = '0;
  logic        recValid;
  logic        recReady = 1'b0;
  logic [31:0] recAddr;
  logic [15:0] recLen;
  logic        recLast;

  int checks = 0;
  int fails = 0;

  logic [31:0] expAddr [0:63];
  logic [15:0] expLen  [0:63];
  int          expCount;

  always #5 clk = ~clk;

  extra_read_predictor uut (
    .clk(clk), .rstN(rstN), .descValid(descValid), .descReady(descReady),
    .descMode(descMode), .descSrc(descSrc), .descAcnt(descAcnt),
    .descBcnt(descBcnt), .descStride(descStride), .recValid(recValid),
    .recReady(recReady), .recAddr(recAddr), .recLen(recLen), .recLast(recLast)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // expected records straight from the requirement text
  task automatic predict(input logic [1:0] m, input logic [31:0] s,
                         input logic [15:0] ac, input logic [15:0] bc,
                         input logic [15:0] st);
    logic [31:0] a;
    logic [31:0] endA;
    int x;
    expCount = 0;
    endA = s + 32'(bc) * 32'(ac);
    if (m == 2'd2) begin
      expAddr[0] = endA; expLen[0] = ac; expCount = 1;
    end else if (m != 2'd3) begin
      for (int i = 0; i < int'(bc); i++) begin
        a = s + 32'(i) * 32'(st);
        x = int'(a[11:0]);
        if (x + int'(ac) > 4096) begin
          if (m == 2'd0) begin
            expAddr[expCount] = a + 32'(st); expLen[expCount] = 16'(4096 - x);
            expCount++;
          end else if (expCount == 0) begin
            expAddr[0] = endA; expLen[0] = 16'(4096 - x); expCount = 1;
          end
        end
      end
    end
    if (expCount == 0) begin
      expAddr[0] = '0; expLen[0] = '0; expCount = 1;
    end
  endtask

  task automatic runDesc(input logic [1:0] m, input logic [31:0] s,
                         input logic [15:0] ac, input logic [15:0] bc,
                         input logic [15:0] st, input bit stall);
    int got = 0;
    bit done = 0;
    bit held = 0;
    logic [31:0] hAddr;
    logic [15:0] hLen;
    logic hLast;
    string tag;
    predict(m, s, ac, bc, st);
    tag = (m == 2'd0) ? "R3" : (m == 2'd1) ? "R6" : (m == 2'd2) ? "R7" : "R8";
    if (expCount == 1 && expLen[0] == 0 && m != 2'd2) tag = "R8";
    @(negedge clk);
    descValid = 1'b1; descMode = m; descSrc = s; descAcnt = ac;
    descBcnt = bc; descStride = st;
    @(posedge clk);
    @(negedge clk);
    descValid = 1'b0;
    #1;
    check(descReady == 1'b0, "R2 busy after accept", 64'(descReady), 64'd0);
    while (!done) begin
      @(negedge clk);
      recReady = stall ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (recValid) begin
        if (held)
          check(recAddr == hAddr && recLen == hLen && recLast == hLast,
                "R9 hold under stall", {recAddr, recLen, 15'd0, recLast},
                {hAddr, hLen, 15'd0, hLast});
        if (recReady) begin
          held = 0;
          if (got < expCount) begin
            check(recAddr == expAddr[got], {tag, " addr"}, 64'(recAddr),
                  64'(expAddr[got]));
            check(recLen == expLen[got], {tag, " len"}, 64'(recLen),
                  64'(expLen[got]));
          end
          check(recLast == (got == expCount - 1), "R4 last flag",
                64'(recLast), 64'(got == expCount - 1));
          if (m == 2'd0 && recLen != 0)
            check(recLen < ac, "R5 len below ACNT", 64'(recLen), 64'(ac));
          got++;
          if (recLast) done = 1;
        end else begin
          held = 1; hAddr = recAddr; hLen = recLen; hLast = recLast;
        end
      end
    end
    @(negedge clk);
    recReady = 1'b0;
    #1;
    check(got == expCount, "R4 record count", 64'(got), 64'(expCount));
    check(descReady == 1'b1, "R2 ready after last", 64'(descReady), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    finishRun();
  end

  initial begin
    logic [31:0] s;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(descReady == 1'b1, "R1 ready after reset", 64'(descReady), 64'd1);
    check(recValid == 1'b0, "R1 no record after reset", 64'(recValid), 64'd0);

    // directed corners
    runDesc(2'd0, 32'h0000_0FF0, 16'd20, 16'd5, 16'h0400, 1'b1);  // R3 several pages
    runDesc(2'd0, 32'h0000_1000, 16'd8,  16'd4, 16'd8,    1'b0);  // R8 no crossing
    runDesc(2'd0, 32'h0000_0FF0, 16'd32, 16'd0, 16'h0400, 1'b0);  // R8 zero count
    runDesc(2'd3, 32'h1234_5FF0, 16'd32, 16'd4, 16'd32,   1'b0);  // R8 mode 3
    runDesc(2'd2, 32'h0000_0FF0, 16'd8,  16'd4, 16'd8,    1'b1);  // R7 merged
    runDesc(2'd1, 32'h0000_0FF8, 16'd16, 16'd3, 16'h1000, 1'b1);  // R6 later crossings ignored
    runDesc(2'd1, 32'h0000_0F00, 16'd16, 16'd4, 16'd16,   1'b0);  // R8 single, none
    runDesc(2'd0, 32'hFFFF_FF00, 16'd48, 16'd8, 16'h0030, 1'b1);  // R10 wraparound
    runDesc(2'd2, 32'hFFFF_FFF0, 16'd32, 16'd2, 16'd32,   1'b0);  // R10 merged wrap

    // constrained random
    for (int k = 0; k < 80; k++) begin
      s = $urandom;
      if ($urandom % 2 == 0) s[11:0] = 12'hFFF - 12'($urandom % 96);
      runDesc(2'($urandom % 4), s, 16'(1 + $urandom % 64), 16'($urandom % 25),
              16'($urandom % 16'h1400), 1'b1);
    end
    finishRun();
  end

endmodule